// File: doc/BRIEF.md
# Dynamic Address Assignment Sequencer

This block runs the controller side of the I3C entry-to-dynamic-address-assignment flow. A single 32-bit command word is taken over a valid/ready handshake. The block opens the flow with a broadcast write start and the assignment CCC byte. It then walks a run of device-address-table entries. For each target it issues a repeated start to the broadcast address and reads the target's 8-byte identity: a 48-bit provisional ID, then the bus characteristic byte, then the device characteristic byte. It then sends back the pre-programmed dynamic address for that entry.

Every bus step goes through a byte-level action interface with four operations: start, send, receive and stop. Each returns a done pulse that carries an ack or nack flag. For each assigned device the block writes a four-word characteristic-table entry, advances a rolling table pointer and pushes two identity words toward the receive data buffer. If requested, it ends the command with a STOP and with one response word that reports the error code and the number of devices left unassigned.

The controller is a single state machine. Its states are S_IDLE, S_OPEN (broadcast start), S_CCC (CCC byte), S_DEV_START (per-device repeated start), S_READ (eight identity reads), S_ADDR (address byte), S_LOG (table write and first identity word), S_RX2 (second identity word), S_STOP and S_RESP. Its transitions are:
- S_IDLE to S_OPEN when a valid command is accepted.
- S_OPEN to S_CCC on ack.
- S_CCC to S_DEV_START on ack, or to finish when the count is zero.
- S_DEV_START to S_READ on ack.
- S_READ loops on itself until the eighth byte, then goes to S_ADDR.
- S_ADDR to S_LOG on ack.
- S_LOG to S_RX2.
- S_RX2 to S_DEV_START, or to finish after the last device.
- Any nack goes to finish.
- Finish means S_STOP when terminate is set, otherwise S_RESP when a response is requested, otherwise S_IDLE.
- S_STOP to S_RESP or S_IDLE.
- S_RESP to S_IDLE.

Top module: `daa_sequencer`

## Requirements
- R1: The command word is laid out LSB first as: attribute [2:0], transaction ID [6:3], CCC [14:7], start index [20:16], device count [25:21], response request [26] and terminate request [30]. A command is taken when cmd_valid and cmd_ready are both high at a clock edge. busy is high from the next cycle until the flow ends, and cmd_ready equals not busy.
- R2: A command is ignored when cap_assign is low or when the attribute is not 3. An ignored command causes no bus action and no response, and busy stays low.
- R3: The flow opens with a start operation (bus_op 0) to address 7'h7E with bus_rnw 0. This is followed by a send operation (bus_op 1) of the command's CCC byte. A nack on either step skips all devices and gives error code 4. An operation's outputs stay stable until its done pulse.
- R4: Each device begins with a repeated start to 7'h7E with bus_rnw 0. A nack there ends the loop with error code 4.
- R5: After that start, exactly eight receive operations (bus_op 2) are made. The first six bytes form the provisional ID, most significant byte first, then one byte of bus characteristics and one byte of device characteristics. A nack on any receive ends the command with error code 5.
- R6: The address byte sent is {dynamic address, parity bit}, where the parity bit makes the count of ones in the byte odd. The dynamic address comes from address-table entry (start index + device number). An entry at index 6 or above reads as address 0. A nack on the address byte ends the loop with error code 5.
- R7: For each assigned device, dct_we is pulsed for one cycle with dct_slot = start index + device number. The four words on that pulse are: ID[31:0]; {16'h0, ID[47:32]}; {16'h0, bus char byte, device char byte}; {25'h0, dynamic address}. rx_push is high on that cycle with ID[31:0] and on the following cycle with {device char, bus char, ID[47:32]}.
- R8: cur_index advances by one on each table write and wraps to 0 when the incremented value reaches tbl_depth divided by 4.
- R9: When the terminate request is set, a stop operation (bus_op 3) is issued after the last action, including after an error. When it is clear, no stop is issued.
- R10: When the response request is set, one resp_push is produced as the last cycle of the command. Its layout is error code [31:28] (0 none, 4 broadcast nack, 5 assignment nack), transaction ID [27:24], zero [23:16], and [15:0] = device count minus devices assigned. When the response request is clear, no response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_assign | input | 1 | Capability: address assignment supported |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_word | input | 32 | Address-assign command word |
| busy | output | 1 | Sequence in progress |
| dat_we | input | 1 | Address-table write strobe |
| dat_idx | input | 3 | Address-table write index |
| dat_addr | input | 7 | Dynamic address to store |
| tbl_depth | input | 8 | Configured characteristic table depth in words |
| cur_index | output | 8 | Present characteristic-table pointer |
| bus_req | output | 1 | Bus action requested |
| bus_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| bus_addr | output | 7 | Address for a start |
| bus_rnw | output | 1 | Direction for a start (1 read) |
| bus_wdata | output | 8 | Byte to send |
| bus_done | input | 1 | Action finished |
| bus_nack | input | 1 | Action was not acknowledged |
| bus_rdata | input | 8 | Received byte, valid with bus_done |
| dct_we | output | 1 | Characteristic-table entry write |
| dct_slot | output | 6 | Entry index written |
| dct_word0 | output | 32 | ID[31:0] |
| dct_word1 | output | 32 | ID[47:32] |
| dct_word2 | output | 32 | Characteristic bytes |
| dct_word3 | output | 32 | Assigned dynamic address |
| rx_push | output | 1 | Identity word toward receive buffer |
| rx_data | output | 32 | Identity word |
| resp_push | output | 1 | Response word valid |
| resp_data | output | 32 | Response word |

## Verification
Two functions can fall in the same cycle: the characteristic-table write to an entry and the wrap of the rolling pointer. Both happen in S_LOG. The bench keeps the table depth at 16, so the pointer wraps every fourth assignment. A sweep over every start index from 0 to 7 and every device count from 1 to 4 then puts the wrap at many places inside a single command. After each command the bench compares the written slot, the four words, the receive words and cur_index with a pointer model of its own. Error exits are provoked by nacks injected at each bus step, and the bench judges the error code, the remaining count and whether a stop was issued.

// File: rtl/daa_pkg.sv
package daa_pkg;
    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_SEND  = 2'd1,
        BUS_RECV  = 2'd2,
        BUS_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_OPEN, S_CCC, S_DEV_START, S_READ,
        S_ADDR, S_LOG, S_RX2, S_STOP, S_RESP
    } seq_state_e;

    localparam logic [6:0] BCAST_ADDR      = 7'h7E;
    localparam logic [2:0] ATTR_ASSIGN     = 3'd3;
    localparam logic [3:0] ERR_NONE        = 4'd0;
    localparam logic [3:0] ERR_BCAST_NACK  = 4'd4;
    localparam logic [3:0] ERR_ASSIGN_NACK = 4'd5;
    localparam int         ID_BYTES        = 8;

    typedef struct packed {
        logic       rsv31;
        logic       term;
        logic [2:0] rsv27;
        logic       resp_req;
        logic [4:0] count;
        logic [4:0] first;
        logic       rsv15;
        logic [7:0] ccc;
        logic [3:0] tid;
        logic [2:0] attr;
    } assign_cmd_t;
endpackage

// File: rtl/daa_addr_table.sv
module daa_addr_table #(
    parameter int NUM      = 6,
    parameter int WR_IDX_W = 3,
    parameter int RD_IDX_W = 6,
    parameter int AW       = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WR_IDX_W-1:0] wr_idx,
    input  logic [AW-1:0]       wr_addr,
    input  logic [RD_IDX_W-1:0] rd_idx,
    output logic [AW-1:0]       rd_addr
);
    logic [NUM*AW-1:0] flat;

    for (genvar g = 0; g < NUM; g++) begin : g_entry
        logic [AW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_idx == WR_IDX_W'(g))
                q <= wr_addr;
        end
        assign flat[g*AW +: AW] = q;
    end

    // Indices outside the table fall through to address 0.
    always_comb begin
        rd_addr = '0;
        for (int i = 0; i < NUM; i++)
            if (rd_idx == RD_IDX_W'(i))
                rd_addr = flat[i*AW +: AW];
    end
endmodule

// File: rtl/daa_index_ptr.sv
module daa_index_ptr #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] depth,
    input  logic          advance,
    output logic [PW-1:0] ptr
);
    logic [PW-1:0] limit;
    logic [PW-1:0] nxt;

    assign limit = depth >> 2;
    assign nxt   = ptr + PW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (advance)
            ptr <= (nxt >= limit) ? '0 : nxt;
    end

    // R8: each advance steps by one or wraps to zero
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ptr == '0) || (ptr == $past(ptr) + PW'(1)));
endmodule

// File: rtl/daa_id_capture.sv
module daa_id_capture #(
    parameter int NBYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  shift,
    input  logic [7:0]            byte_in,
    output logic [NBYTES*8-1:0]   id
);
    localparam int W = NBYTES * 8;

    // Bytes arrive most significant first, so shift toward the top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            id <= '0;
        else if (clear)
            id <= '0;
        else if (shift)
            id <= {id[W-9:0], byte_in};
    end
endmodule

// File: rtl/daa_sequencer.sv
module daa_sequencer
    import daa_pkg::*;
#(
    parameter int NUM_DEV   = 6,
    parameter int TBL_IDX_W = $clog2(NUM_DEV),
    parameter int CMD_IDX_W = 5,
    parameter int SLOT_W    = CMD_IDX_W + 1,
    parameter int DEPTH_W   = 8,
    parameter int AW        = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_assign,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [31:0]          cmd_word,
    output logic                 busy,
    input  logic                 dat_we,
    input  logic [TBL_IDX_W-1:0] dat_idx,
    input  logic [AW-1:0]        dat_addr,
    input  logic [DEPTH_W-1:0]   tbl_depth,
    output logic [DEPTH_W-1:0]   cur_index,
    output logic                 bus_req,
    output logic [1:0]           bus_op,
    output logic [AW-1:0]        bus_addr,
    output logic                 bus_rnw,
    output logic [7:0]           bus_wdata,
    input  logic                 bus_done,
    input  logic                 bus_nack,
    input  logic [7:0]           bus_rdata,
    output logic                 dct_we,
    output logic [SLOT_W-1:0]    dct_slot,
    output logic [31:0]          dct_word0,
    output logic [31:0]          dct_word1,
    output logic [31:0]          dct_word2,
    output logic [31:0]          dct_word3,
    output logic                 rx_push,
    output logic [31:0]          rx_data,
    output logic                 resp_push,
    output logic [31:0]          resp_data
);
    localparam int ID_W  = ID_BYTES * 8;
    localparam int BCW   = $clog2(ID_BYTES);

    seq_state_e      state, state_nx;
    assign_cmd_t     cmd_in, cmd_q;
    logic [3:0]      err_q;
    logic [4:0]      done_cnt;
    logic [BCW-1:0]  byte_cnt;
    logic [ID_W-1:0] id;
    logic [AW-1:0]   dyn_addr;
    logic [SLOT_W-1:0] cur_slot;
    logic            start_ok;
    logic            last_dev;
    seq_state_e      fin_st;
    logic            ack, nack;

    logic [47:0]     pid;
    logic [7:0]      bcr, dcr;

    assign cmd_in   = assign_cmd_t'(cmd_word);
    assign busy     = (state != S_IDLE);
    assign cmd_ready = !busy;
    assign start_ok = cmd_valid && cmd_ready && cap_assign && (cmd_in.attr == ATTR_ASSIGN);
    assign cur_slot = SLOT_W'(cmd_q.first) + SLOT_W'(done_cnt);
    assign last_dev = (done_cnt + 5'd1 == cmd_q.count);
    assign fin_st   = cmd_q.term ? S_STOP : (cmd_q.resp_req ? S_RESP : S_IDLE);
    assign ack      = bus_done && !bus_nack;
    assign nack     = bus_done && bus_nack;

    assign pid = id[ID_W-1:16];
    assign bcr = id[15:8];
    assign dcr = id[7:0];

    daa_addr_table #(
        .NUM(NUM_DEV), .WR_IDX_W(TBL_IDX_W), .RD_IDX_W(SLOT_W), .AW(AW)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(dat_we), .wr_idx(dat_idx),
        .wr_addr(dat_addr), .rd_idx(cur_slot), .rd_addr(dyn_addr)
    );

    daa_index_ptr #(.PW(DEPTH_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .depth(tbl_depth),
        .advance(state == S_LOG), .ptr(cur_index)
    );

    daa_id_capture #(.NBYTES(ID_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .clear(state == S_DEV_START && bus_done),
        .shift(state == S_READ && ack),
        .byte_in(bus_rdata), .id(id)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (start_ok) state_nx = S_OPEN;
            S_OPEN:      if (nack) state_nx = fin_st;
                         else if (ack) state_nx = S_CCC;
            S_CCC:       if (nack) state_nx = fin_st;
                         else if (ack) state_nx = (cmd_q.count == '0) ? fin_st : S_DEV_START;
            S_DEV_START: if (nack) state_nx = fin_st;
                         else if (ack) state_nx = S_READ;
            S_READ:      if (nack) state_nx = fin_st;
                         else if (ack && byte_cnt == BCW'(ID_BYTES - 1)) state_nx = S_ADDR;
            S_ADDR:      if (nack) state_nx = fin_st;
                         else if (ack) state_nx = S_LOG;
            S_LOG:       state_nx = S_RX2;
            S_RX2:       state_nx = last_dev ? fin_st : S_DEV_START;
            S_STOP:      if (bus_done) state_nx = cmd_q.resp_req ? S_RESP : S_IDLE;
            S_RESP:      state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Command context, error code and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            err_q    <= ERR_NONE;
            done_cnt <= '0;
            byte_cnt <= '0;
        end else begin
            if (state == S_IDLE && start_ok) begin
                cmd_q    <= cmd_in;
                err_q    <= ERR_NONE;
                done_cnt <= '0;
            end
            if (nack) begin
                if (state == S_OPEN || state == S_CCC || state == S_DEV_START)
                    err_q <= ERR_BCAST_NACK;
                else if (state == S_READ || state == S_ADDR)
                    err_q <= ERR_ASSIGN_NACK;
            end
            if (state == S_DEV_START)
                byte_cnt <= '0;
            else if (state == S_READ && ack)
                byte_cnt <= byte_cnt + BCW'(1);
            if (state == S_RX2)
                done_cnt <= done_cnt + 5'd1;
        end
    end

    // Outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_op    = BUS_START;
        bus_addr  = BCAST_ADDR;
        bus_rnw   = 1'b0;
        bus_wdata = 8'h00;
        dct_we    = 1'b0;
        rx_push   = 1'b0;
        rx_data   = {bcr, dcr, pid[47:32]};
        resp_push = 1'b0;
        unique case (state)
            S_OPEN, S_DEV_START: bus_req = 1'b1;
            S_CCC: begin
                bus_req   = 1'b1;
                bus_op    = BUS_SEND;
                bus_wdata = cmd_q.ccc;
            end
            S_READ: begin
                bus_req = 1'b1;
                bus_op  = BUS_RECV;
            end
            S_ADDR: begin
                bus_req   = 1'b1;
                bus_op    = BUS_SEND;
                bus_wdata = {dyn_addr, ~^dyn_addr};
            end
            S_LOG: begin
                dct_we  = 1'b1;
                rx_push = 1'b1;
                rx_data = pid[31:0];
            end
            S_RX2: begin
                rx_push = 1'b1;
                rx_data = {dcr, bcr, pid[47:32]};
            end
            S_STOP: begin
                bus_req = 1'b1;
                bus_op  = BUS_STOP;
            end
            S_RESP:  resp_push = 1'b1;
            default: ;
        endcase
    end

    assign dct_slot  = cur_slot;
    assign dct_word0 = pid[31:0];
    assign dct_word1 = {16'h0000, pid[47:32]};
    assign dct_word2 = {16'h0000, bcr, dcr};
    assign dct_word3 = {{(32-AW){1'b0}}, dyn_addr};
    assign resp_data = {err_q, cmd_q.tid, 8'h00, 16'(cmd_q.count - done_cnt)};

    // R3: a pending bus action holds its operation until done
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_op) && $stable(bus_wdata));
    // R7: a table write is followed by the second identity word
    p_rx_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dct_we |=> rx_push && !dct_we);
    // R10: the response is the last cycle of a command
    p_resp_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_push |=> !busy);
    // R2: nothing is driven while no command runs
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req && !resp_push && !rx_push && !dct_we);
    // R1: an accepted command makes the block busy next cycle
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> busy);
endmodule

// File: tb/daa_sequencer_tb.sv
module daa_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 4;   // tbl_depth 16 / 4

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_assign = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_word = '0;
    logic        busy;
    logic        dat_we = 1'b0;
    logic [2:0]  dat_idx = '0;
    logic [6:0]  dat_addr = '0;
    logic [7:0]  tbl_depth = 8'd16;
    logic [7:0]  cur_index;
    logic        bus_req;
    logic [1:0]  bus_op;
    logic [6:0]  bus_addr;
    logic        bus_rnw;
    logic [7:0]  bus_wdata;
    logic        bus_done = 1'b0;
    logic        bus_nack = 1'b0;
    logic [7:0]  bus_rdata = '0;
    logic        dct_we;
    logic [5:0]  dct_slot;
    logic [31:0] dct_word0, dct_word1, dct_word2, dct_word3;
    logic        rx_push;
    logic [31:0] rx_data;
    logic        resp_push;
    logic [31:0] resp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    daa_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cap_assign(cap_assign),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .busy(busy), .dat_we(dat_we), .dat_idx(dat_idx), .dat_addr(dat_addr),
        .tbl_depth(tbl_depth), .cur_index(cur_index),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_nack(bus_nack),
        .bus_rdata(bus_rdata), .dct_we(dct_we), .dct_slot(dct_slot),
        .dct_word0(dct_word0), .dct_word1(dct_word1), .dct_word2(dct_word2),
        .dct_word3(dct_word3), .rx_push(rx_push), .rx_data(rx_data),
        .resp_push(resp_push), .resp_data(resp_data)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Bus model configuration and observations
    int       cfg_present = 32;
    bit       cfg_nack_open = 0;
    bit       cfg_nack_ccc = 0;
    int       cfg_rd_dev = -1;
    int       cfg_rd_byte = 0;
    int       cfg_addr_dev = -1;
    logic [7:0] seed = 8'h31;
    int       op_cnt = 0;
    int       stop_cnt = 0;
    int       bad_start = 0;
    logic [7:0] ccc_seen = '0;
    logic [7:0] addr_sent [32];
    int       bst = 0;
    int       rb = 0;

    function automatic logic [7:0] id_byte(input logic [7:0] s, input int d, input int j);
        return s + 8'(d * 37) + 8'(j * 11);
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (!busy) bst = 0;
            if (bus_req) begin
                bit nk;
                nk = 0;
                op_cnt++;
                case (bus_op)
                    2'd0: begin
                        if (bus_addr != 7'h7E || bus_rnw) bad_start++;
                        if (bst == 0) nk = cfg_nack_open;
                        else nk = (bst - 1) >= cfg_present;
                        bst++;
                        rb = 0;
                    end
                    2'd1: begin
                        if (bst == 1) begin
                            ccc_seen = bus_wdata;
                            nk = cfg_nack_ccc;
                        end else begin
                            addr_sent[(bst-2) % 32] = bus_wdata;
                            nk = (bst - 2) == cfg_addr_dev;
                        end
                    end
                    2'd2: begin
                        bus_rdata = id_byte(seed, bst - 2, rb);
                        nk = ((bst - 2) == cfg_rd_dev) && (rb == cfg_rd_byte);
                        rb++;
                    end
                    default: stop_cnt++;
                endcase
                bus_nack = nk;
                bus_done = 1'b1;
                @(negedge clk);
                bus_done = 1'b0;
                bus_nack = 1'b0;
            end
        end
    end

    // Output monitor
    logic [5:0]  m_slot [512];
    logic [31:0] m_w0 [512], m_w1 [512], m_w2 [512], m_w3 [512];
    logic [31:0] m_rx [1024];
    logic [31:0] m_resp [256];
    int n_dct = 0, n_rx = 0, n_resp = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (dct_we) begin
                m_slot[n_dct % 512] = dct_slot;
                m_w0[n_dct % 512] = dct_word0;
                m_w1[n_dct % 512] = dct_word1;
                m_w2[n_dct % 512] = dct_word2;
                m_w3[n_dct % 512] = dct_word3;
                n_dct++;
            end
            if (rx_push) begin
                m_rx[n_rx % 1024] = rx_data;
                n_rx++;
            end
            if (resp_push) begin
                m_resp[n_resp % 256] = resp_data;
                n_resp++;
            end
        end
    end

    bit wd_hit = 0;
    initial begin
        repeat (190000) @(posedge clk);
        wd_hit = 1;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    logic [6:0] tbl [6];
    int ptr_m = 0;

    function automatic logic [31:0] mk(input logic [3:0] tid, input logic [7:0] ccc,
                                       input int idx, input int cnt, input bit roc,
                                       input bit toc, input logic [2:0] attr);
        return {1'b0, toc, 3'b000, roc, 5'(cnt), 5'(idx), 1'b0, ccc, tid, attr};
    endfunction

    task automatic send_cmd(input logic [31:0] w, input bit exp_acc);
        int t;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(exp_acc ? "R1 busy after accept" : "R2 busy stays low", busy, exp_acc);
        t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) chk("R1 command completes", 1, 0);
    endtask

    task automatic run_assign(input logic [3:0] tid, input logic [7:0] ccc, input int idx,
                              input int cnt, input bit roc, input bit toc);
        int d0, r0, p0, s0, err, assigned;
        bit opened;
        d0 = n_dct; r0 = n_rx; p0 = n_resp; s0 = stop_cnt;
        send_cmd(mk(tid, ccc, idx, cnt, roc, toc, 3'd3), 1);
        err = 0; assigned = 0; opened = 0;
        if (cfg_nack_open) err = 4;
        else begin
            opened = 1;
            if (cfg_nack_ccc) err = 4;
            else begin
                for (int d = 0; d < cnt; d++) begin
                    if (d >= cfg_present) begin err = 4; break; end
                    if (d == cfg_rd_dev) begin err = 5; break; end
                    if (d == cfg_addr_dev) begin err = 5; break; end
                    assigned++;
                end
            end
        end
        if (opened) chk("R3 CCC byte sent", ccc_seen, ccc);
        chk("R3 R4 starts to broadcast write", bad_start, 0);
        chk("R7 table writes", n_dct - d0, assigned);
        chk("R7 rx words", n_rx - r0, 2 * assigned);
        for (int d = 0; d < assigned; d++) begin
            logic [7:0] b [8];
            logic [6:0] a;
            int k;
            for (int j = 0; j < 8; j++) b[j] = id_byte(seed, d, j);
            a = (idx + d < 6) ? tbl[idx + d] : 7'h00;
            k = (d0 + d) % 512;
            chk("R6 address byte with odd parity", addr_sent[d], {a, ~^a});
            chk("R7 slot", m_slot[k], 6'(idx + d));
            chk("R5 R7 word0", m_w0[k], {b[2], b[3], b[4], b[5]});
            chk("R5 R7 word1", m_w1[k], {16'h0, b[0], b[1]});
            chk("R5 R7 word2", m_w2[k], {16'h0, b[6], b[7]});
            chk("R6 R7 word3", m_w3[k], {25'h0, a});
            chk("R7 rx first", m_rx[(r0 + 2*d) % 1024], {b[2], b[3], b[4], b[5]});
            chk("R7 rx second", m_rx[(r0 + 2*d + 1) % 1024], {b[7], b[6], b[0], b[1]});
            ptr_m = (ptr_m + 1 >= LIMIT) ? 0 : ptr_m + 1;
        end
        chk("R8 pointer", cur_index, 8'(ptr_m));
        chk("R9 stop issued", stop_cnt - s0, toc ? 1 : 0);
        chk("R10 response count", n_resp - p0, roc ? 1 : 0);
        if (roc)
            chk("R10 response word", m_resp[p0 % 256],
                {4'(err), tid, 8'h00, 16'(cnt - assigned)});
    endtask

    task automatic clear_faults();
        cfg_present = 32; cfg_nack_open = 0; cfg_nack_ccc = 0;
        cfg_rd_dev = -1; cfg_addr_dev = -1;
    endtask

    initial begin
        for (int i = 0; i < 6; i++) tbl[i] = 7'(8 + 5 * i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset ready", cmd_ready, 1);
        chk("R2 reset bus idle", bus_req, 0);
        chk("R8 reset pointer", cur_index, 0);
        for (int i = 0; i < 6; i++) begin
            dat_we = 1'b1; dat_idx = 3'(i); dat_addr = tbl[i];
            @(negedge clk);
        end
        dat_we = 1'b0;

        // R2: capability off, then wrong attribute
        begin
            int o0, p0;
            o0 = op_cnt; p0 = n_resp;
            cap_assign = 1'b0;
            send_cmd(mk(4'h1, 8'h07, 0, 2, 1, 1, 3'd3), 0);
            repeat (5) @(negedge clk);
            chk("R2 no bus action without capability", op_cnt - o0, 0);
            chk("R2 no response without capability", n_resp - p0, 0);
            cap_assign = 1'b1;
            send_cmd(mk(4'h2, 8'h07, 0, 2, 1, 1, 3'd1), 0);
            repeat (5) @(negedge clk);
            chk("R2 no bus action for other attribute", op_cnt - o0, 0);
            chk("R2 no response for other attribute", n_resp - p0, 0);
        end

        clear_faults();
        run_assign(4'h3, 8'h07, 0, 3, 1, 1);           // R3 R7 nominal
        run_assign(4'h4, 8'h07, 4, 2, 1, 1);           // R8 wrap mid-command
        run_assign(4'h5, 8'h07, 5, 3, 1, 0);           // R6 index past table
        cfg_present = 2;  run_assign(4'h6, 8'h07, 0, 4, 1, 1); clear_faults();  // R4
        cfg_nack_open = 1; run_assign(4'h7, 8'h07, 1, 3, 1, 1); clear_faults(); // R3
        cfg_nack_ccc = 1; run_assign(4'h8, 8'h07, 1, 3, 1, 1); clear_faults();  // R3
        cfg_rd_dev = 1; cfg_rd_byte = 3; run_assign(4'h9, 8'h07, 0, 3, 1, 1); clear_faults(); // R5
        cfg_rd_dev = 0; cfg_rd_byte = 7; run_assign(4'hA, 8'h07, 2, 2, 1, 0); clear_faults(); // R5
        cfg_addr_dev = 0; run_assign(4'hB, 8'h07, 3, 2, 1, 1); clear_faults();  // R6
        run_assign(4'hC, 8'h07, 1, 2, 0, 0);           // R9 R10 neither requested
        run_assign(4'hD, 8'h07, 0, 0, 1, 1);           // R10 zero count
        // Sweep: every start index and device count (R6 R7 R8)
        for (int idx = 0; idx < 8; idx++)
            for (int cnt = 1; cnt <= 4; cnt++) begin
                seed = 8'(idx * 13 + cnt * 7);
                run_assign(4'(idx + cnt), 8'(8'h07 + cnt), idx, cnt, 1, cnt[0]);
            end

        if (!wd_hit) begin
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule